// File: doc/BRIEF.md
# Interrupt Priority Store with Secure and Non-Secure Views

The block holds one 8-bit priority for each shared interrupt of an interrupt controller. Software reaches it through single-cycle requests. A request is either a byte access, which covers one interrupt, or a word access, which covers four neighbouring interrupts. Every request carries a security attribute. Interrupts below `FIRST_SHARED` are internal ones, and they have no storage here. Interrupts at or above `NUM_IRQ` are not implemented.

When security is enabled (`sec_en` high), a non-secure request is treated in two ways.
- If the interrupt is group 0 (secure), the request does not see its priority at all.
- If the interrupt is non-secure, the request works through a translated view. A read returns the stored value shifted left by one bit. A write squeezes the written value into the upper-half codes 0x80..0xFF, which are the less urgent levels. Non-secure software therefore cannot program a priority more urgent than any level that secure software keeps for itself.

Each accepted write produces a one-cycle update strobe. The strobe gives the first interrupt touched and the number of interrupts touched, so that downstream priority-selection logic can re-evaluate them.

Top module: `prio_store`

## Requirements
- R1: After reset every stored priority is 0x00, and `rd_valid` and `upd_valid` are low.
- R2: A word access addresses interrupts `B..B+3`, where `B` is `req_idx` with its two low bits cleared. Interrupt `B+k` sits in data bits `[8k+7:8k]`. A byte access addresses interrupt `req_idx` alone, in bits `[7:0]`, and reads back zero in bits `[31:8]`.
- R3: A secure request, or any request while `sec_en` is low, reads and writes the stored value unchanged.
- R4: While `sec_en` is high, a non-secure request to an interrupt whose `grp_ns` bit is 1 behaves as follows. A read returns `(v << 1) & 0xFF`, where `v` is the stored value. A write of byte `b` stores `0x80 | (b >> 1)`.
- R5: While `sec_en` is high, a non-secure request to an interrupt whose `grp_ns` bit is 0 reads zero in that lane and leaves that lane's stored value unchanged. Other lanes of the same word are unaffected.
- R6: A word write is dropped completely, and raises no strobe, if `B < FIRST_SHARED` or `B+3 >= NUM_IRQ`.
- R7: A byte access, or a lane of a word read, whose interrupt is below `FIRST_SHARED` or at or above `NUM_IRQ` reads zero. A byte write to such an interrupt changes nothing and raises no strobe.
- R8: A read request gives `rd_valid` high in the next cycle, with the read result on `rd_data`.
- R9: An accepted write (one that passes the range checks) raises `upd_valid` for exactly the next cycle. In that cycle `upd_base` is the first interrupt addressed and `upd_cnt` is 4 for a word access or 1 for a byte access. Reads and rejected writes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_en | input | 1 | Security enabled (two security states) |
| grp_ns | input | NUM_IRQ | Per-interrupt group: 1 = non-secure group, 0 = group 0 (secure) |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = four-priority word access, 0 = byte access |
| req_secure | input | 1 | Security attribute of the request |
| req_idx | input | IDX_W | Interrupt index (byte offset into the array) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| upd_valid | output | 1 | Update strobe after an accepted write |
| upd_base | output | IDX_W | First interrupt touched by that write |
| upd_cnt | output | 3 | Number of interrupts touched (1 or 4) |

## Verification
A corrupted stored priority, or a write steered to the wrong lane, appears on `rd_data` for the first read of that interrupt after the write. Because the bench sweeps every index, this shows within one sweep. A wrong security decision shows in the very next read: hidden lanes read back a nonzero value, visible lanes read zero, or a non-secure read has a 1 in the bit that the left shift must clear. A wrong range decision shows in the cycle after the write, either as a missing or extra `upd_valid` or as an out-of-range lane that becomes nonzero.

// File: rtl/prio_store.sv
module prio_store #(
  parameter int NUM_IRQ      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int IDX_W        = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_en,
  input  logic [NUM_IRQ-1:0] grp_ns,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_word,
  input  logic               req_secure,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [31:0]        req_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               upd_valid,
  output logic [IDX_W-1:0]   upd_base,
  output logic [2:0]         upd_cnt
);
  localparam logic [IDX_W:0] LO = (IDX_W+1)'(FIRST_SHARED);
  localparam logic [IDX_W:0] HI = (IDX_W+1)'(NUM_IRQ);

  logic [IDX_W-1:0] base;
  logic [IDX_W:0]   base_x, last_x;
  logic             ns_view, wr_ok, rd_req;
  logic [31:0]      rd_next;
  logic [8*NUM_IRQ-1:8*FIRST_SHARED] flat;

  assign base    = req_word ? {req_idx[IDX_W-1:2], 2'b00} : req_idx;
  assign base_x  = {1'b0, base};
  assign last_x  = base_x + {{(IDX_W-1){1'b0}}, req_word, req_word};
  assign ns_view = sec_en && !req_secure;
  assign rd_req  = req_valid && !req_write;
  assign wr_ok   = req_valid && req_write && (base_x >= LO) && (last_x < HI);

  for (genvar i = FIRST_SHARED; i < NUM_IRQ; i++) begin : g_ent
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);
    logic       hit;
    logic [7:0] b;
    logic [7:0] val;

    assign hit = req_word ? (base[IDX_W-1:2] == ME[IDX_W-1:2]) : (base == ME);
    assign b   = req_word ? req_wdata[8*(i%4) +: 8] : req_wdata[7:0];

    always_ff @(posedge clk) begin
      if (!rst_n)
        val <= 8'h00;
      else if (wr_ok && hit && !(ns_view && !grp_ns[i]))
        val <= ns_view ? {1'b1, b[7:1]} : b;
    end

    assign flat[8*i +: 8] = val;
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < 4; k++) begin
      for (int i = FIRST_SHARED; i < NUM_IRQ; i++) begin
        if ((k == 0 || req_word) &&
            (base_x + (IDX_W+1)'(k) == (IDX_W+1)'(i)) &&
            !(ns_view && !grp_ns[i]))
          rd_next[8*k +: 8] = ns_view ? {flat[8*i +: 7], 1'b0} : flat[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      upd_valid <= 1'b0;
      upd_base  <= '0;
      upd_cnt   <= '0;
    end else begin
      rd_valid  <= rd_req;
      upd_valid <= wr_ok;
      if (rd_req)
        rd_data <= rd_next;
      if (wr_ok) begin
        upd_base <= base;
        upd_cnt  <= req_word ? 3'd4 : 3'd1;
      end
    end
  end
endmodule

// File: rtl/prio_store_chk.sv
module prio_store_chk #(
  parameter int NUM_IRQ      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int IDX_W        = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_en,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_word,
  input logic             req_secure,
  input logic [IDX_W-1:0] req_idx,
  input logic             rd_valid,
  input logic [31:0]      rd_data,
  input logic             upd_valid,
  input logic [IDX_W-1:0] upd_base,
  input logic [2:0]       upd_cnt
);
  a_r8_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  a_r9_no_strobe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !upd_valid);

  a_r9_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_cnt == 3'd1 || upd_cnt == 3'd4));

  a_r6_word_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_cnt == 3'd4) |->
      (int'(upd_base) >= FIRST_SHARED && int'(upd_base) + 3 < NUM_IRQ && upd_base[1:0] == 2'b00));

  a_r7_low_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_word && int'(req_idx) < FIRST_SHARED) |=> (rd_data == 32'h0));

  a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_word) |=> (rd_data[31:8] == 24'h0));

  a_r4_ns_read_even: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && sec_en && !req_secure) |=> ((rd_data & 32'h0101_0101) == 32'h0));
endmodule

bind prio_store prio_store_chk #(
  .NUM_IRQ(NUM_IRQ), .FIRST_SHARED(FIRST_SHARED), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_en(sec_en),
  .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
  .req_secure(req_secure), .req_idx(req_idx),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .upd_valid(upd_valid), .upd_base(upd_base), .upd_cnt(upd_cnt)
);

// File: tb/prio_store_test.sv
`timescale 1ns/1ps
module prio_store_test;
  localparam int N  = 64;
  localparam int FS = 32;
  localparam int IW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec_en = 1'b0;
  logic [N-1:0]  grp_ns = '0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_secure = 1'b1;
  logic [IW-1:0] req_idx = '0;
  logic [31:0]   req_wdata = '0;
  logic          rd_valid, upd_valid;
  logic [31:0]   rd_data;
  logic [IW-1:0] upd_base;
  logic [2:0]    upd_cnt;

  int n_run = 0, n_fail = 0;
  logic [7:0] m [N];

  always #10 clk = ~clk;

  prio_store #(.NUM_IRQ(N), .FIRST_SHARED(FS), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .grp_ns(grp_ns),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_secure(req_secure), .req_idx(req_idx), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .upd_valid(upd_valid), .upd_base(upd_base), .upd_cnt(upd_cnt));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input bit word, input bit sec, input int idx);
    logic [31:0] r = '0;
    int base = word ? (idx & ~3) : idx;
    bit ns = sec_en && !sec;
    for (int k = 0; k < (word ? 4 : 1); k++) begin
      int j = base + k;
      if (j >= FS && j < N && !(ns && !grp_ns[j]))
        r[8*k +: 8] = ns ? {m[j][6:0], 1'b0} : m[j];
    end
    return r;
  endfunction

  task automatic acc(input bit w, input bit word, input bit sec, input int idx,
                     input logic [31:0] d, input string tag);
    int base = word ? (idx & ~3) : idx;
    int last = base + (word ? 3 : 0);
    bit ok = w && base >= FS && last < N;
    bit ns = sec_en && !sec;
    logic [31:0] e = '0;
    if (!w) e = exp_read(word, sec, idx);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_word = word; req_secure = sec;
    req_idx = IW'(idx); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (w) begin
      if (ok)
        chk({tag, " R9 strobe"}, {upd_valid, 6'(upd_base), upd_cnt},
            {1'b1, 6'(base), word ? 3'd4 : 3'd1});
      else
        chk({tag, " R6/R7 no strobe"}, 64'(upd_valid), 64'd0);
      if (ok)
        for (int k = 0; k < (word ? 4 : 1); k++) begin
          logic [7:0] b = d[8*k +: 8];
          if (!(ns && !grp_ns[base+k]))
            m[base+k] = ns ? (8'h80 | (b >> 1)) : b;
        end
    end else begin
      chk({tag, " R8 rd_valid"}, 64'(rd_valid), 64'd1);
      chk({tag, " read data"}, 64'(rd_data), 64'(e));
    end
  endtask

  task automatic sweep_reads(input bit sec, input string tag);
    for (int i = 0; i < 128; i++) acc(0, 0, sec, i, 0, {tag, " byte R2"});
    for (int i = 0; i < 128; i += 4) acc(0, 1, sec, i, 0, {tag, " word R2"});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < N; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_valid after reset", 64'(rd_valid), 0);
    chk("R1 upd_valid after reset", 64'(upd_valid), 0);
    sweep_reads(1, "R1 R7 reset");

    for (int i = 0; i < 128; i += 4)
      acc(1, 1, 1, i, {8'(i*37+3), 8'(i*37+2), 8'(i*37+1), 8'(i*37)}, "R3 R6 sec word wr");
    sweep_reads(1, "R3 after word writes");

    for (int i = 0; i < 128; i++) acc(1, 0, 1, i, {24'hFFFFFF, 8'(i*13+7)}, "R7 R9 sec byte wr");
    sweep_reads(1, "R7 after byte writes");

    acc(1, 1, 1, 45, 32'hA1B2C3D4, "R2 unaligned word wr");
    acc(0, 1, 1, 43, 0, "R2 unaligned word rd");
    acc(0, 0, 1, 44, 0, "R2 lane0 byte rd");
    acc(0, 0, 1, 47, 0, "R2 lane3 byte rd");

    sec_en = 1'b1;
    grp_ns = 64'hAAAA_5555_F0F0_0F0F;
    for (int i = 0; i < 128; i += 4)
      acc(1, 1, 0, i, {8'(i*11+200), 8'(i*7+1), 8'(i*5+90), 8'(i*3+17)}, "R4 R5 ns word wr");
    sweep_reads(0, "R4 R5 ns view");
    sweep_reads(1, "R3 R5 secure view");
    for (int i = 0; i < 128; i++) acc(1, 0, 0, i, 32'(i*29+3), "R4 R5 ns byte wr");
    sweep_reads(0, "R4 ns view 2");
    sweep_reads(1, "R5 secure view 2");

    sec_en = 1'b0;
    for (int i = 0; i < 128; i += 4)
      acc(1, 1, 0, i, {8'(i+4), 8'(255-i), 8'(i*2), 8'(i^8'h5A)}, "R3 ns word wr sec off");
    sweep_reads(0, "R3 ns reads sec off");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule